// File: doc/BRIEF.md
# Counter-Tree Parallel Multiplier

This block multiplies two unsigned K-bit operands into a 2K-bit product. Every bit product a[i]&b[j] is formed at once, one row per bit of `b`, shifted to its weight. The rows then go through a tree of carry-save levels. Each level takes rows three at a time and compresses them into two using (3,2) counters, which are full adders. Each counter keeps its sum at the weight it came from and sends its carry one weight up, so no carry crosses a column inside the tree. Rows left over at a level pass straight to the next one. When only two rows remain, a ripple-carry adder adds them to give the product. Its lowest cell has no carry-in and is a (2,2) counter, a half adder.

The parameter PIPE inserts 0 to 3 register stages at cuts spread evenly over the tree levels. With PIPE=0 the block is purely combinational. A valid bit travels beside the data with the same latency. A new operand pair may be presented on every cycle. Each pipeline register loads only when the valid bit entering it is set. Reset is synchronous and active high, and it clears only the valid bits.

Top module: `ctmul_top`

## Requirements
- R1: When `out_valid` is high, `product` equals the unsigned product of the `a` and `b` that were presented with `in_valid` high exactly PIPE cycles earlier, over the full 2K-bit width.
- R2: The largest operands (all K bits set on both inputs) give exactly 2^(2K) - 2^(K+1) + 1, with no carry lost inside the tree.
- R3: If either operand is zero, the delivered product is zero.
- R4: `out_valid` equals `in_valid` delayed by exactly PIPE clock cycles. With PIPE=0 it follows `in_valid` in the same cycle, and `product` follows `a` and `b` combinationally.
- R5: Pairs presented on consecutive cycles come out on consecutive cycles, in order, each with its own correct product.
- R6: With PIPE of 1 or more, a clock edge with `rst` high clears every valid stage. `out_valid` is low in the cycle that follows, and no pair in flight at that edge is ever delivered.
- R7: With PIPE=0, `rst` has no effect, and `out_valid` still equals `in_valid` while `rst` is high.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low PIPE cycles later. It does not disturb the products delivered before or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid | input | 1 | Marks `a` and `b` as a pair to multiply this cycle |
| a | input | K | Unsigned multiplicand |
| b | input | K | Unsigned multiplier |
| out_valid | output | 1 | Marks `product` as a result |
| product | output | 2K | Unsigned product |

## Verification
The assertions take the operands and `in_valid` as settled values at each rising edge. With PIPE=0 they also assume these inputs are stable for the whole cycle, because the product is then checked in the cycle the pair is presented. The latency and product properties look back PIPE cycles, so they wait until that many edges have passed with reset low. A pair whose history runs into a reset is not judged. The bench changes every input only at the falling edge, which keeps inputs steady around the rising edge. It also asserts reset in the middle of a stream while `in_valid` is high, so the discard path is exercised.

// File: rtl/ctmul_pkg.sv
package ctmul_pkg;

  // Load strobes from control to datapath, one per register cut (at most 3).
  typedef struct packed {
    logic [2:0] load;
  } stageStrobe_t;

  // Row count entering reduction level `lvl` for a K-row start.
  function automatic int rowsAfter(input int k, input int lvl);
    int n;
    n = k;
    for (int i = 0; i < lvl; i++) n = 2 * (n / 3) + (n % 3);
    return n;
  endfunction

  // Number of carry-save levels needed to reach two rows.
  function automatic int levelCount(input int k);
    int n;
    int c;
    n = k;
    c = 0;
    while (n > 2) begin
      n = 2 * (n / 3) + (n % 3);
      c++;
    end
    return c;
  endfunction

  // Level boundary after which register cut `idx` sits.
  function automatic int cutAt(input int levels, input int pipe, input int idx);
    return ((idx + 1) * (levels + 1)) / (pipe + 1);
  endfunction

  // Register cut index placed after level `lvl`, or -1 for none.
  function automatic int stageOfLevel(input int levels, input int pipe, input int lvl);
    int s;
    s = -1;
    for (int i = 0; i < pipe; i++)
      if (cutAt(levels, pipe, i) == lvl) s = i;
    return s;
  endfunction

endpackage

// File: rtl/ctmul_counter32.sv
// (3,2) counter: three bits of one weight in, sum at that weight, carry one up.
module ctmul_counter32 (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic sum,
  output logic carry
);
  assign sum   = x ^ y ^ z;
  assign carry = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/ctmul_counter22.sv
// (2,2) counter: two bits of one weight in.
module ctmul_counter22 (
  input  logic x,
  input  logic y,
  output logic sum,
  output logic carry
);
  assign sum   = x ^ y;
  assign carry = x & y;
endmodule

// File: rtl/ctmul_ctrl.sv
module ctmul_ctrl
  import ctmul_pkg::*;
#(
  parameter int PIPE = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         outValid,
  output stageStrobe_t strobe
);

  if (PIPE == 0) begin : gComb
    logic unusedCtl;
    assign unusedCtl = clk ^ rst;
    assign outValid  = inValid;
    assign strobe    = '0;
  end else begin : gPiped
    // vq[i] is the valid bit after i register cuts.
    logic [PIPE:1] vq;

    always_ff @(posedge clk) begin
      if (rst) begin
        vq <= '0;
      end else begin
        vq[1] <= inValid;
        for (int i = 2; i <= PIPE; i++) vq[i] <= vq[i-1];
      end
    end

    always_comb begin
      strobe         = '0;
      strobe.load[0] = inValid;
      for (int i = 1; i < PIPE; i++) strobe.load[i] = vq[i];
    end

    assign outValid = vq[PIPE];
  end

endmodule

// File: rtl/ctmul_dp.sv
module ctmul_dp
  import ctmul_pkg::*;
#(
  parameter int K    = 8,
  parameter int PIPE = 2
) (
  input  logic             clk,
  input  stageStrobe_t     strobe,
  input  logic [K-1:0]     a,
  input  logic [K-1:0]     b,
  output logic [2*K-1:0]   product
);

  localparam int W = 2 * K;
  localparam int L = levelCount(K);

  logic unusedStrobe;
  assign unusedStrobe = ^strobe;

  // Bit-product rows, one per multiplier bit, at their weight.
  logic [W-1:0] ppRows [K];
  for (genvar r = 0; r < K; r++) begin : gPp
    assign ppRows[r] = W'({K{b[r]}} & a) << r;
  end

  // Carry-save reduction levels.
  for (genvar l = 0; l < L; l++) begin : lvl
    localparam int NI = rowsAfter(K, l);
    localparam int G  = NI / 3;
    localparam int RM = NI % 3;
    localparam int NO = 2 * G + RM;
    localparam int ST = stageOfLevel(L, PIPE, l + 1);

    logic [W-1:0] rowsIn  [NI];
    logic [W-1:0] nxt     [NO];
    logic [W-1:0] rowsOut [NO];

    if (l == 0) begin : gSrc
      assign rowsIn = ppRows;
    end else begin : gSrc
      assign rowsIn = lvl[l-1].rowsOut;
    end

    for (genvar g = 0; g < G; g++) begin : gGrp
      logic [W-1:0] s;
      logic [W-2:0] c;
      logic         unusedTopCarry;
      for (genvar bt = 0; bt < W; bt++) begin : gBit
        if (bt == W - 1) begin : gTop
          ctmul_counter32 uCnt (
            .x(rowsIn[3*g][bt]), .y(rowsIn[3*g+1][bt]), .z(rowsIn[3*g+2][bt]),
            .sum(s[bt]), .carry(unusedTopCarry));
        end else begin : gMid
          ctmul_counter32 uCnt (
            .x(rowsIn[3*g][bt]), .y(rowsIn[3*g+1][bt]), .z(rowsIn[3*g+2][bt]),
            .sum(s[bt]), .carry(c[bt]));
        end
      end
      assign nxt[2*g]   = s;
      assign nxt[2*g+1] = {c, 1'b0};
    end

    for (genvar r = 0; r < RM; r++) begin : gPass
      assign nxt[2*G+r] = rowsIn[3*G+r];
    end

    if (ST >= 0) begin : gReg
      always_ff @(posedge clk) begin
        if (strobe.load[ST]) rowsOut <= nxt;
      end
    end else begin : gWire
      assign rowsOut = nxt;
    end
  end

  // Final carry-propagate adder over the last two rows.
  logic [W-1:0] opA;
  logic [W-1:0] opB;
  logic [W-1:1] cy;
  logic         unusedCarryOut;

  assign opA = lvl[L-1].rowsOut[0];
  assign opB = lvl[L-1].rowsOut[1];

  for (genvar bt = 0; bt < W; bt++) begin : gRca
    if (bt == 0) begin : gLsb
      ctmul_counter22 uHa (.x(opA[0]), .y(opB[0]), .sum(product[0]), .carry(cy[1]));
    end else if (bt == W - 1) begin : gMsb
      ctmul_counter32 uFa (.x(opA[bt]), .y(opB[bt]), .z(cy[bt]),
                           .sum(product[bt]), .carry(unusedCarryOut));
    end else begin : gMid
      ctmul_counter32 uFa (.x(opA[bt]), .y(opB[bt]), .z(cy[bt]),
                           .sum(product[bt]), .carry(cy[bt+1]));
    end
  end

endmodule

// File: rtl/ctmul_top.sv
module ctmul_top
  import ctmul_pkg::*;
#(
  parameter int K    = 8,
  parameter int PIPE = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [K-1:0]   a,
  input  logic [K-1:0]   b,
  output logic           out_valid,
  output logic [2*K-1:0] product
);

  stageStrobe_t strobe;

  ctmul_ctrl #(.PIPE(PIPE)) uCtrl (
    .clk(clk), .rst(rst), .inValid(in_valid),
    .outValid(out_valid), .strobe(strobe));

  ctmul_dp #(.K(K), .PIPE(PIPE)) uDp (
    .clk(clk), .strobe(strobe), .a(a), .b(b), .product(product));

endmodule

// File: rtl/ctmul_checker.sv
module ctmul_checker #(
  parameter int K    = 8,
  parameter int PIPE = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [K-1:0]   a,
  input logic [K-1:0]   b,
  input logic           out_valid,
  input logic [2*K-1:0] product
);
  localparam int W = 2 * K;
  localparam logic [W-1:0] MAXSQ = W'({K{1'b1}}) * W'({K{1'b1}});

  // Edges seen with reset low, saturating at 3.
  logic [1:0] since;
  logic       armed;
  always_ff @(posedge clk) begin
    armed <= 1'b1;
    if (rst) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  if (PIPE == 0) begin : gComb
    a_r1_product: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> product == W'(a) * W'(b));
    a_r3_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (a == '0 || b == '0)) |-> product == '0);
    a_r2_max: assert property (@(posedge clk) disable iff (rst)
      (in_valid && a == '1 && b == '1) |-> product == MAXSQ);
  end else begin : gPiped
    a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
      (int'(since) >= PIPE) |-> out_valid == $past(in_valid, PIPE));
    a_r1_product: assert property (@(posedge clk) disable iff (rst)
      (int'(since) >= PIPE && out_valid) |->
        product == W'($past(a, PIPE)) * W'($past(b, PIPE)));
    a_r3_zero: assert property (@(posedge clk) disable iff (rst)
      (int'(since) >= PIPE && out_valid &&
       ($past(a, PIPE) == '0 || $past(b, PIPE) == '0)) |-> product == '0);
    a_r6_reset_clears: assert property (@(posedge clk)
      (armed && $past(rst)) |-> !out_valid);
  end
endmodule

bind ctmul_top ctmul_checker #(.K(K), .PIPE(PIPE)) uChk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .product(product));

// File: tb/ctmul_lane.sv
module ctmul_lane #(
  parameter int K    = 8,
  parameter int PIPE = 2
) (
  input  logic clk,
  output int   checks,
  output int   fails,
  output logic done
);
  timeunit 1ns; timeprecision 100ps;
  localparam int W = 2 * K;
  localparam logic [K-1:0] MAXV = '1;

  logic         rst = 1'b1;
  logic         inv = 1'b0;
  logic [K-1:0] a = '0;
  logic [K-1:0] b = '0;
  logic         outValid;
  logic [W-1:0] product;

  ctmul_top #(.K(K), .PIPE(PIPE)) uut (
    .clk(clk), .rst(rst), .in_valid(inv), .a(a), .b(b),
    .out_valid(outValid), .product(product));

  // Behavioural reference: stage i holds what sits after i register cuts.
  logic         pv [0:4];
  logic [K-1:0] pa [0:4];
  logic [K-1:0] pb [0:4];
  logic         lastRst = 1'b1;
  logic         lastOut = 1'b0;

  task automatic checkOutputs();
    logic         ev;
    logic [K-1:0] ea;
    logic [K-1:0] eb;
    logic [W-1:0] ep;
    string        tag;
    if (PIPE == 0) begin ev = inv; ea = a; eb = b; end
    else begin ev = pv[PIPE]; ea = pa[PIPE]; eb = pb[PIPE]; end
    ep = W'(ea) * W'(eb);
    if (PIPE == 0 && rst) tag = "R7";
    else if (PIPE > 0 && lastRst) tag = "R6";
    else if (!ev) tag = "R8";
    else tag = "R4";
    checks++;
    if (outValid !== ev) begin
      fails++;
      $display("FAIL %s K=%0d PIPE=%0d out_valid actual=%0b expected=%0b",
               tag, K, PIPE, outValid, ev);
    end
    if (ev) begin
      if (ea == '0 || eb == '0) tag = "R3";
      else if (ea == MAXV && eb == MAXV) tag = "R2";
      else if (lastOut) tag = "R5";
      else tag = "R1";
      checks++;
      if (product !== ep) begin
        fails++;
        $display("FAIL %s K=%0d PIPE=%0d product actual=%0h expected=%0h",
                 tag, K, PIPE, product, ep);
      end
    end
    lastOut = ev;
  endtask

  task automatic step(input logic r, input logic v, input logic [K-1:0] x,
                      input logic [K-1:0] y);
    @(negedge clk);
    checkOutputs();
    rst = r; inv = v; a = x; b = y;
    for (int i = PIPE; i >= 2; i--) begin
      pv[i] = r ? 1'b0 : pv[i-1];
      pa[i] = pa[i-1];
      pb[i] = pb[i-1];
    end
    if (PIPE >= 1) begin
      pv[1] = r ? 1'b0 : v;
      pa[1] = x;
      pb[1] = y;
    end
    lastRst = r;
  endtask

  function automatic logic [K-1:0] pick();
    int sel;
    sel = int'($urandom % 16);
    if (sel == 0) return '0;
    if (sel == 1) return MAXV;
    if (sel == 2) return K'(1);
    return K'($urandom);
  endfunction

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    for (int i = 0; i <= 4; i++) begin pv[i] = 1'b0; pa[i] = '0; pb[i] = '0; end
    // Reset held with idle inputs: R6/R7 reset state.
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, '0);
    // Directed corners, back to back: R2, R3, R5.
    step(1'b0, 1'b1, MAXV, MAXV);
    step(1'b0, 1'b1, '0, MAXV);
    step(1'b0, 1'b1, MAXV, '0);
    step(1'b0, 1'b1, K'(1), MAXV);
    step(1'b0, 1'b1, MAXV, K'(1));
    for (int i = 0; i < K; i++) step(1'b0, 1'b1, K'(1) << i, MAXV);
    step(1'b0, 1'b1, MAXV, MAXV);
    // Bubble between pairs: R8.
    step(1'b0, 1'b0, MAXV, MAXV);
    step(1'b0, 1'b1, K'(3), K'(5));
    step(1'b0, 1'b0, '0, '0);
    // Random stream with occasional bubbles: R1, R4, R5, R8.
    for (int i = 0; i < 1500; i++)
      step(1'b0, ($urandom % 5) != 0, pick(), pick());
    // Reset in the middle of a stream with valid input: R6, R7.
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, pick(), pick());
    step(1'b1, 1'b1, pick(), pick());
    step(1'b1, 1'b1, pick(), pick());
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, pick(), pick());
    // Drain.
    for (int i = 0; i < PIPE + 3; i++) step(1'b0, 1'b0, '0, '0);
    done = 1'b1;
  end
endmodule

// File: tb/ctmul_top_test.sv
module ctmul_top_test;
  timeunit 1ns; timeprecision 100ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int   c8, f8, c16, f16, c0, f0;
  logic d8, d16, d0;

  ctmul_lane #(.K(8),  .PIPE(2)) uut   (.clk(clk), .checks(c8),  .fails(f8),  .done(d8));
  ctmul_lane #(.K(16), .PIPE(3)) uut16 (.clk(clk), .checks(c16), .fails(f16), .done(d16));
  ctmul_lane #(.K(8),  .PIPE(0)) uut0  (.clk(clk), .checks(c0),  .fails(f0),  .done(d0));

  initial begin
    int cyc;
    int totalChecks;
    int totalFails;
    cyc = 0;
    while (!(d8 === 1'b1 && d16 === 1'b1 && d0 === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    totalChecks = c8 + c16 + c0;
    totalFails  = f8 + f16 + f0;
    if (!(d8 === 1'b1 && d16 === 1'b1 && d0 === 1'b1)) begin
      totalChecks++;
      totalFails++;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", totalChecks, totalFails);
    $finish;
  end
endmodule